// File: doc/BRIEF.md
# Smart-Panel Bus Controller

This block connects a host register port to up to two external smart-panel chips over a shared 16-bit bus. The bus has one chip-select line per chip, a write strobe, a read strobe and a data/command select. The host writes a command or a parameter word, and the block emits one bus write cycle. A 32-bit pixel word is sent as two back-to-back 16-bit data cycles. A write to either fetch register makes the block run one bus read cycle and capture the returned half-word in a receive buffer, which the host can then read.

The host can also launch a frame transfer on behalf of the display controller. While a transfer runs, the block reports busy. Every pixel write and every fetch counts a pixel counter down. When the counter reaches zero, busy clears and a one-cycle frame-done pulse goes out to the display controller's interrupt logic. Per-chip configuration and timing words are only stored with their masks; they shape no waveform. The DMA bypass mode has no behaviour beyond blocking a start.

The host port follows valid/ready rules. A request is taken on a rising edge where `host_valid` and `host_ready` are both high. `host_ready` falls for exactly one cycle after a pixel write (the second half-cycle on the bus) and after a fetch (the capture cycle). `rsp_valid` pulses in the cycle after a read is taken, together with its data. There is no back-pressure on responses.

Top module: `panel_bus_ctrl`

## Requirements
- R1: After reset, the following read values hold. Identity (word 0) reads 0x10. Control (word 3) reads 0x2. System status (word 2) reads 0x1, where bit 0 is reset-done and bit 8 is busy. The pixel counter (word 4) reads 0. The configuration word of each chip bank reads 0x00310000. Chip c's bank starts at word 16+8c.
- R2: Each chip bank keeps six words at offsets 0..5, each written through its own mask. Configuration (offset 0) uses 0x003F1FFF. On/off timing (offset 1) uses 0x3FFFFFFF. Cycle timing (offset 2) uses 0x0FFFFFFF. The three data-cycle words (offsets 3..5) use 0x0F1F0F1F.
- R3: In the control word, bit 0 is enable, bit 1 is bypass, bit 2 selects chip 0 and bit 3 selects chip 1. A write to the command word (5) gives one bus write cycle with dc=0. A write to the parameter word (6) gives one with dc=1. The cycle carries the low 16 bits to every selected chip at once. If no chip is selected, there is no strobe.
- R4: A write to the pixel word (7) gives two consecutive dc=1 write cycles on the selected chips: bits 15:0 first, then bits 31:16.
- R5: A write to word 8 (data fetch, dc=1) or word 9 (status fetch, dc=0) gives one read cycle to the lowest-numbered selected chip. The half-word on `pnl_din` is captured and read back from either word. With no chip selected there is no strobe and the buffer keeps its value.
- R6: Busy is raised by a control write that meets all of these conditions: bit 4 is set, enable is set, bypass is clear, and `panel_mode_en` is high. In addition, the AND of both configuration words must not have bits 3:2 both set.
- R7: Each write to word 7, 8 or 9 decrements the pixel counter, wrapping at zero. A write to word 4 loads the counter.
- R8: When a decrement brings the counter to zero while busy, busy clears and `frame_done` pulses for exactly one cycle.
- R9: A start request while busy changes nothing. A counter load while busy takes effect directly.
- R10: A write to system configuration (word 1) with bit 1 set restores the R1 state of control, counter, busy and chip banks. The stored idle bits are the written value masked with 0x19.
- R11: A valid start while the counter is zero pulses `frame_done` at once and leaves busy low.
- R12: `host_ready` is low for exactly one cycle after a pixel write or a fetch is taken, and stays high after a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can take a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Register word address |
| host_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| panel_mode_en | input | 1 | Display controller panel-mode enable |
| frame_done | output | 1 | One-cycle frame-done pulse |
| pnl_we | output | 1 | Bus write strobe |
| pnl_re | output | 1 | Bus read strobe |
| pnl_dc | output | 1 | 1 = data cycle, 0 = command cycle |
| pnl_cs | output | 2 | Chip selects, one per chip |
| pnl_dout | output | 16 | Bus write data |
| pnl_din | input | 16 | Bus read data |

## Verification
A wrong bus-sequencer state shows up on the strobes and chip selects in the cycle after the host request is taken. It also appears as a missing or extra half-word, or a stuck `host_ready`, by the next cycle. A corrupted pixel counter or busy flag shows only later: either as a `frame_done` pulse on the wrong pixel write, or as the busy bit in system status disagreeing with the arithmetic count of writes since the start. The bench therefore re-reads status and the counter after each access of a transfer.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [2:0] {
    OP_NONE, OP_CMD, OP_PARAM, OP_DATA, OP_FETCH_D, OP_FETCH_S
  } bus_op_e;

  localparam logic [REG_AW-1:0] A_ID      = 5'd0;
  localparam logic [REG_AW-1:0] A_SYSCFG  = 5'd1;
  localparam logic [REG_AW-1:0] A_SYSSTAT = 5'd2;
  localparam logic [REG_AW-1:0] A_CTRL    = 5'd3;
  localparam logic [REG_AW-1:0] A_PIXCNT  = 5'd4;
  localparam logic [REG_AW-1:0] A_CMD     = 5'd5;
  localparam logic [REG_AW-1:0] A_PARAM   = 5'd6;
  localparam logic [REG_AW-1:0] A_DATA    = 5'd7;
  localparam logic [REG_AW-1:0] A_RDDATA  = 5'd8;
  localparam logic [REG_AW-1:0] A_RDSTAT  = 5'd9;
  localparam int BANK_BASE   = 16;
  localparam int BANK_STRIDE = 8;
  localparam int BANK_WORDS  = 6;

  localparam logic [31:0] ID_VALUE  = 32'h10;
  localparam logic [31:0] CFG_RST   = 32'h0031_0000;
  localparam logic [4:0]  IDLE_MASK = 5'h19;
  localparam logic [3:0]  CTRL_RST  = 4'h2;

  function automatic logic [31:0] bank_mask(input logic [2:0] idx);
    case (idx)
      3'd0:    bank_mask = 32'h003F_1FFF;
      3'd1:    bank_mask = 32'h3FFF_FFFF;
      3'd2:    bank_mask = 32'h0FFF_FFFF;
      default: bank_mask = 32'h0F1F_0F1F;
    endcase
  endfunction
endpackage

// File: rtl/pbc_chip_bank.sv
module pbc_chip_bank
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [2:0]  sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] cfg
);
  logic [31:0] word_q [BANK_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BANK_WORDS; i++) word_q[i] <= (i == 0) ? CFG_RST : 32'h0;
    end else if (clr) begin
      for (int i = 0; i < BANK_WORDS; i++) word_q[i] <= (i == 0) ? CFG_RST : 32'h0;
    end else if (wr_en && (int'(sel) < BANK_WORDS)) begin
      word_q[sel] <= wdata & bank_mask(sel);
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < BANK_WORDS; i++)
      if (int'(sel) == i) rdata = word_q[i];
  end

  assign cfg = word_q[0];
endmodule

// File: rtl/pbc_bus_engine.sv
module pbc_bus_engine
  import pbc_pkg::*;
#(
  parameter int NCHIP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_op_e          op,
  input  logic [31:0]      wdata,
  input  logic [NCHIP-1:0] sel,
  output logic             ready,
  output logic             pnl_we,
  output logic             pnl_re,
  output logic             pnl_dc,
  output logic [NCHIP-1:0] pnl_cs,
  output logic [15:0]      pnl_dout,
  input  logic [15:0]      pnl_din,
  output logic [15:0]      rxbuf
);
  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_CAP} eng_st_e;
  eng_st_e     st_q;
  logic [15:0] hi_q;
  logic [NCHIP-1:0] pick;

  // lowest-numbered selected chip wins a fetch
  always_comb begin
    pick = '0;
    for (int i = NCHIP - 1; i >= 0; i--)
      if (sel[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
  end

  assign ready = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pnl_we   <= 1'b0;
      pnl_re   <= 1'b0;
      pnl_dc   <= 1'b0;
      pnl_cs   <= '0;
      pnl_dout <= '0;
      hi_q     <= '0;
      rxbuf    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          pnl_we <= 1'b0;
          pnl_re <= 1'b0;
          pnl_cs <= '0;
          case (op)
            OP_CMD, OP_PARAM, OP_DATA: begin
              pnl_we   <= |sel;
              pnl_cs   <= sel;
              pnl_dc   <= (op != OP_CMD);
              pnl_dout <= wdata[15:0];
              hi_q     <= wdata[31:16];
              if (op == OP_DATA) st_q <= ST_HIGH;
            end
            OP_FETCH_D, OP_FETCH_S: begin
              pnl_re <= |sel;
              pnl_cs <= pick;
              pnl_dc <= (op == OP_FETCH_D);
              st_q   <= ST_CAP;
            end
            default: ;
          endcase
        end
        ST_HIGH: begin
          pnl_dout <= hi_q;
          st_q     <= ST_IDLE;
        end
        default: begin
          if (pnl_re) rxbuf <= pnl_din;
          pnl_re <= 1'b0;
          pnl_cs <= '0;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pbc_xfer.sv
module pbc_xfer #(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [PIX_W-1:0] load_val,
  input  logic             dec,
  input  logic             start,
  output logic [PIX_W-1:0] count,
  output logic             busy,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (clr) begin
      count <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        count <= load_val;
      end else if (dec) begin
        count <= count - PIX_W'(1);
        if (busy && count == PIX_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start && !busy) begin
        if (count == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_bus_ctrl.sv
module panel_bus_ctrl
  import pbc_pkg::*;
#(
  parameter int NCHIP = 2,
  parameter int PIX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic              panel_mode_en,
  output logic              frame_done,
  output logic              pnl_we,
  output logic              pnl_re,
  output logic              pnl_dc,
  output logic [NCHIP-1:0]  pnl_cs,
  output logic [15:0]       pnl_dout,
  input  logic [15:0]       pnl_din
);
  localparam int CTRL_W = 2 + NCHIP;
  localparam int HI_W   = REG_AW - 3;

  logic              acc, wr, rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [4:0]        idle_q;
  logic              soft_clr, start_req, cfg_ok, dec, load;
  bus_op_e           op;
  logic [15:0]       rxbuf;
  logic [PIX_W-1:0]  pix_cnt;
  logic              xfer_busy;
  logic [31:0]       rd_mux;
  logic [31:0]       bank_rd  [NCHIP];
  logic [31:0]       bank_cfg [NCHIP];
  logic [NCHIP-1:0]  bank_hit;
  logic [31:0]       cfg_and;

  assign acc = host_valid && host_ready;
  assign wr  = acc && host_we;
  assign rd  = acc && !host_we;

  assign soft_clr = wr && host_addr == A_SYSCFG && host_wdata[1];

  always_comb begin
    cfg_and = '1;
    for (int c = 0; c < NCHIP; c++) cfg_and = cfg_and & bank_cfg[c];
  end
  assign cfg_ok = (cfg_and[3:2] != 2'b11);

  assign start_req = wr && host_addr == A_CTRL && host_wdata[4] && host_wdata[0]
                     && !host_wdata[1] && panel_mode_en && cfg_ok;
  assign dec  = wr && (host_addr == A_DATA || host_addr == A_RDDATA || host_addr == A_RDSTAT);
  assign load = wr && host_addr == A_PIXCNT;

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      case (host_addr)
        A_CMD:    op = OP_CMD;
        A_PARAM:  op = OP_PARAM;
        A_DATA:   op = OP_DATA;
        A_RDDATA: op = OP_FETCH_D;
        A_RDSTAT: op = OP_FETCH_S;
        default:  op = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_W'(CTRL_RST);
      idle_q <= '0;
    end else begin
      if (soft_clr) ctrl_q <= CTRL_W'(CTRL_RST);
      else if (wr && host_addr == A_CTRL) ctrl_q <= host_wdata[CTRL_W-1:0];
      if (wr && host_addr == A_SYSCFG) idle_q <= host_wdata[4:0] & IDLE_MASK;
    end
  end

  for (genvar c = 0; c < NCHIP; c++) begin : g_bank
    assign bank_hit[c] = (host_addr[REG_AW-1:3] == HI_W'((BANK_BASE + BANK_STRIDE * c) / 8))
                         && (int'(host_addr[2:0]) < BANK_WORDS);
    pbc_chip_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .wr_en (wr && bank_hit[c]),
      .sel   (host_addr[2:0]),
      .wdata (host_wdata),
      .rdata (bank_rd[c]),
      .cfg   (bank_cfg[c])
    );
  end

  pbc_bus_engine #(.NCHIP(NCHIP)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wdata    (host_wdata),
    .sel      (ctrl_q[2 +: NCHIP]),
    .ready    (host_ready),
    .pnl_we   (pnl_we),
    .pnl_re   (pnl_re),
    .pnl_dc   (pnl_dc),
    .pnl_cs   (pnl_cs),
    .pnl_dout (pnl_dout),
    .pnl_din  (pnl_din),
    .rxbuf    (rxbuf)
  );

  pbc_xfer #(.PIX_W(PIX_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr),
    .load     (load),
    .load_val (host_wdata[PIX_W-1:0]),
    .dec      (dec),
    .start    (start_req),
    .count    (pix_cnt),
    .busy     (xfer_busy),
    .done     (frame_done)
  );

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      A_ID:               rd_mux = ID_VALUE;
      A_SYSCFG:           rd_mux = 32'(idle_q);
      A_SYSSTAT:          rd_mux = {23'd0, xfer_busy, 8'd1};
      A_CTRL:             rd_mux = 32'(ctrl_q);
      A_PIXCNT:           rd_mux = 32'(pix_cnt);
      A_RDDATA, A_RDSTAT: rd_mux = 32'(rxbuf);
      default:
        for (int c = 0; c < NCHIP; c++)
          if (bank_hit[c]) rd_mux = bank_rd[c];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/panel_bus_ctrl_chk.sv
module panel_bus_ctrl_chk
  import pbc_pkg::*;
#(
  parameter int NCHIP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_we,
  input logic [REG_AW-1:0] host_addr,
  input logic              frame_done,
  input logic              pnl_we,
  input logic              pnl_re,
  input logic [NCHIP-1:0]  pnl_cs,
  input logic              busy,
  input logic [3:0]        ctrl_q
);
  // R3: never both strobes, and a strobe always has a chip
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(pnl_we && pnl_re));
  a_r3_strobe_has_chip: assert property (@(posedge clk) disable iff (!rst_n)
    (pnl_we || pnl_re) |-> (pnl_cs != '0));
  // R5: a fetch addresses exactly one chip
  a_r5_fetch_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_re |-> ($countones(pnl_cs) == 1));
  // R6: busy only rises while enabled and not in bypass
  a_r6_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ctrl_q[0] && !ctrl_q[1]));
  // R8: a completion is never seen with busy still high
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);
  // R12: pixel write stalls the next cycle
  a_r12_stall_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_we && host_addr == A_DATA) |=> !host_ready);
  // R12: the stall lasts a single cycle
  a_r12_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |=> host_ready);
endmodule

bind panel_bus_ctrl panel_bus_ctrl_chk #(.NCHIP(NCHIP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .frame_done (frame_done),
  .pnl_we     (pnl_we),
  .pnl_re     (pnl_re),
  .pnl_cs     (pnl_cs),
  .busy       (xfer_busy),
  .ctrl_q     (ctrl_q)
);

// File: tb/panel_bus_ctrl_test.sv
module panel_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        panel_mode_en = 1'b1;
  logic        frame_done;
  logic        pnl_we, pnl_re, pnl_dc;
  logic [1:0]  pnl_cs;
  logic [15:0] pnl_dout, pnl_din;

  int n_chk = 0, n_fail = 0, nlog = 0, ndone = 0;
  logic [15:0] ld  [64];
  logic [1:0]  lcs [64];
  logic        ldc [64];
  logic        lre [64];

  always #5 clk = ~clk;

  assign pnl_din = {(pnl_dc ? 8'hD5 : 8'hC3), 6'd0, pnl_cs};

  panel_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .panel_mode_en(panel_mode_en),
    .frame_done(frame_done), .pnl_we(pnl_we), .pnl_re(pnl_re), .pnl_dc(pnl_dc),
    .pnl_cs(pnl_cs), .pnl_dout(pnl_dout), .pnl_din(pnl_din)
  );

  always @(negedge clk) begin
    if (frame_done) ndone++;
    if ((pnl_we || pnl_re) && nlog < 64) begin
      ld[nlog] = pnl_dout; lcs[nlog] = pnl_cs; ldc[nlog] = pnl_dc; lre[nlog] = pnl_re;
      nlog++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    while (!host_ready) begin @(negedge clk); #1; end
    host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); #1;
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    while (!host_ready) begin @(negedge clk); #1; end
    host_valid = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk); #1;
    host_valid = 1'b0;
    d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  function automatic logic [31:0] bmask(input int idx);
    case (idx)
      0: return 32'h003F_1FFF;
      1: return 32'h3FFF_FFFF;
      2: return 32'h0FFF_FFFF;
      default: return 32'h0F1F_0F1F;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, prev;
    int base, nd0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    hr(5'd0, v);  chk("R1 id", v, 32'h10);
    hr(5'd3, v);  chk("R1 ctrl", v, 32'h2);
    hr(5'd2, v);  chk("R1 sysstat", v, 32'h1);
    hr(5'd4, v);  chk("R1 pixcnt", v, 32'h0);
    hr(5'd16, v); chk("R1 cfg chip0", v, 32'h0031_0000);
    hr(5'd24, v); chk("R1 cfg chip1", v, 32'h0031_0000);

    // R2 masked bank words, both chips
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 6; r++) begin
        hw(5'(16 + 8 * c + r), 32'hFFFF_FFFF);
        hr(5'(16 + 8 * c + r), v);
        chk("R2 mask", v, bmask(r));
      end
    hw(5'd16, 0); hw(5'd24, 0);

    // R3 / R4 / R12 over every chip-select pattern
    for (int s = 0; s < 4; s++) begin
      hw(5'd3, 32'(s << 2) | 32'h1);
      base = nlog;
      hw(5'd5, 32'h0000_AB00 | 32'(s));
      chk("R12 ready after cmd", 32'(host_ready), 1);
      idle(2);
      chk("R3 cmd cycles", 32'(nlog - base), (s != 0) ? 1 : 0);
      if (s != 0) begin
        chk("R3 cmd cs", 32'(lcs[base]), 32'(s));
        chk("R3 cmd dc", 32'(ldc[base]), 0);
        chk("R3 cmd data", 32'(ld[base]), 32'hAB00 | 32'(s));
      end
      base = nlog;
      hw(5'd6, 32'hFFFF_3C00 | 32'(s));
      idle(2);
      chk("R3 param cycles", 32'(nlog - base), (s != 0) ? 1 : 0);
      if (s != 0) begin
        chk("R3 param dc", 32'(ldc[base]), 1);
        chk("R3 param data", 32'(ld[base]), 32'h3C00 | 32'(s));
      end
      base = nlog;
      hw(5'd7, {16'h7000 + 16'(s), 16'h0E00 + 16'(s)});
      chk("R12 stall after data", 32'(host_ready), 0);
      idle(1);
      chk("R12 stall one cycle", 32'(host_ready), 1);
      idle(1);
      chk("R4 data cycles", 32'(nlog - base), (s != 0) ? 2 : 0);
      if (s != 0) begin
        chk("R4 low first", 32'(ld[base]), 32'h0E00 + 32'(s));
        chk("R4 high second", 32'(ld[base + 1]), 32'h7000 + 32'(s));
        chk("R4 dc", 32'(ldc[base + 1]), 1);
        chk("R4 cs", 32'(lcs[base + 1]), 32'(s));
      end
    end

    // R5 fetches with chip-0 priority
    for (int s = 0; s < 4; s++) begin
      hw(5'd3, 32'(s << 2) | 32'h1);
      for (int k = 0; k < 2; k++) begin
        hr(5'd8, prev);
        base = nlog;
        hw((k == 0) ? 5'd8 : 5'd9, 32'h0);
        chk("R12 stall after fetch", 32'(host_ready), 0);
        idle(1);
        hr((k == 0) ? 5'd9 : 5'd8, v);
        chk("R5 fetch cycles", 32'(nlog - base), (s != 0) ? 1 : 0);
        if (s == 0) chk("R5 buffer kept", v, prev);
        else begin
          chk("R5 buffer", v, {16'd0, (k == 0) ? 8'hD5 : 8'hC3, 6'd0, (s[0] ? 2'b01 : 2'b10)});
          chk("R5 read strobe", 32'(lre[base]), 1);
        end
      end
    end

    // R7 counter load and decrement
    hw(5'd4, 10);
    hw(5'd7, 0); hw(5'd9, 0); hw(5'd8, 0);
    hr(5'd4, v); chk("R7 decrement", v, 7);
    hw(5'd4, 0); hw(5'd7, 0);
    hr(5'd4, v); chk("R7 wrap", v, 32'h0000_FFFF);

    // R6 / R8 start-condition sweep
    for (int c = 0; c < 16; c++) begin
      logic en, byp, mode, blk, expb;
      en = c[0]; byp = c[1]; mode = c[2]; blk = c[3];
      expb = en && !byp && mode && !blk;
      hw(5'd16, blk ? 32'hC : 32'h0);
      hw(5'd24, blk ? 32'hC : 32'h0);
      panel_mode_en = mode;
      hw(5'd4, 2);
      nd0 = ndone;
      hw(5'd3, 32'h10 | 32'h4 | (32'(byp) << 1) | 32'(en));
      hr(5'd2, v); chk("R6 start gate", v, 32'h1 | (32'(expb) << 8));
      if (expb) begin
        hw(5'd7, 0);
        hr(5'd2, v); chk("R8 busy mid frame", v, 32'h101);
        chk("R8 no early done", 32'(ndone), 32'(nd0));
        hw(5'd7, 0);
        idle(1);
        hr(5'd2, v); chk("R8 busy cleared", v, 32'h1);
      end
      chk("R8 done count", 32'(ndone), 32'(nd0 + (expb ? 1 : 0)));
    end
    panel_mode_en = 1'b1;
    hw(5'd16, 32'hC); hw(5'd24, 32'h4); hw(5'd4, 1);
    hw(5'd3, 32'h15);
    hr(5'd2, v); chk("R6 partial cfg allows", v, 32'h101);
    hw(5'd7, 0);
    hw(5'd16, 0); hw(5'd24, 0);

    // R9 start ignored while busy, load takes effect
    hw(5'd4, 3); hw(5'd3, 32'h15);
    nd0 = ndone;
    hw(5'd3, 32'h15);
    hr(5'd4, v); chk("R9 count unchanged", v, 3);
    hr(5'd2, v); chk("R9 still busy", v, 32'h101);
    hw(5'd4, 1);
    hw(5'd7, 0); idle(1);
    chk("R9 reload ends frame", 32'(ndone), 32'(nd0 + 1));
    hr(5'd2, v); chk("R9 idle", v, 32'h1);

    // R11 zero-count start
    hw(5'd4, 0);
    nd0 = ndone;
    hw(5'd3, 32'h15); idle(1);
    chk("R11 instant done", 32'(ndone), 32'(nd0 + 1));
    hr(5'd2, v); chk("R11 not busy", v, 32'h1);

    // R10 soft reset
    hw(5'd4, 5); hw(5'd3, 32'h1D); hw(5'd16, 32'h1234);
    nd0 = ndone;
    hw(5'd1, 32'hFF);
    hr(5'd3, v);  chk("R10 ctrl", v, 32'h2);
    hr(5'd16, v); chk("R10 cfg", v, 32'h0031_0000);
    hr(5'd2, v);  chk("R10 busy cleared", v, 32'h1);
    hr(5'd4, v);  chk("R10 count", v, 0);
    hr(5'd1, v);  chk("R10 idle mask", v, 32'h19);
    chk("R10 no done", 32'(ndone), 32'(nd0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule